// File: doc/BRIEF.md
# Bus-Addressed Control Byte Register

This block is a two-wire serial bus target that holds a single 8-bit control register. A bus master writes it with one short transfer: a START condition, an address byte carrying a hard-wired 7-bit address and a direction bit, one data byte, and a STOP condition. The register output drives downstream controls directly. A transfer with the direction bit set to read instead shifts the stored byte back out to the master.

Both bus lines are sampled with the system clock through a short synchronizer. START and STOP are recognised on the synchronized lines. The target answers on the shared data line only through an open-drain enable, which either pulls the line low or releases it. A power-good input gates every acknowledge. While it is low the target stays silent and the register keeps its value.

The controller has eight states. `ST_IDLE` waits for START. `ST_ADDR` shifts in the address byte. `ST_ADDR_ACK` drives the address acknowledge. `ST_WDATA` shifts in the data byte. `ST_WDATA_ACK` drives the data acknowledge and commits the byte at its end. `ST_RDATA` shifts the register out. `ST_RDATA_ACK` lets the master's acknowledge clock pass. `ST_DONE` ignores the bus until STOP or START.

The transitions are:
- A STOP in any state goes to `ST_IDLE`.
- A START in any state goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address with power good. Otherwise it goes to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_WDATA` or `ST_RDATA`, chosen by the direction bit.
- `ST_WDATA` goes to `ST_WDATA_ACK` with power good, or to `ST_DONE` without it.
- `ST_WDATA_ACK` goes to `ST_DONE`.
- `ST_RDATA` goes to `ST_RDATA_ACK` after eight bits.
- `ST_RDATA_ACK` goes to `ST_DONE`.

Top module: `busctl_target`

## Requirements
- R1: After reset the register output `ctrl_q` is 0x00 and `sda_oe` is 0 (data line released).
- R2: A falling data line while the clock line is high (START) begins reception of an address byte. A rising data line while the clock line is high (STOP) returns the block to idle with the data line released.
- R3: The address byte is received most significant bit first, each bit sampled while the clock is high. Its upper seven bits are compared with the address 7'b0001000. On a match the block sets `sda_oe` to 1 (drive low) for the whole high period of the ninth clock.
- R4: On an address mismatch the block does not acknowledge. It then ignores all clocks and data until the next START, and `ctrl_q` is unchanged.
- R5: While `pwr_ok` is 0 the block acknowledges neither an address nor a data byte, and `ctrl_q` is unchanged.
- R6: In a write transfer (direction bit 0), the data byte is received MSB first and acknowledged with `sda_oe` = 1 during its ninth clock. It is copied into `ctrl_q` only when that ninth clock falls.
- R7: Only one data byte is accepted per transfer. Any further byte before STOP is not acknowledged and does not change `ctrl_q`.
- R8: In a read transfer (direction bit 1), after the address acknowledge the block presents `ctrl_q` MSB first: `sda_oe` = 1 for a 0 bit and 0 for a 1 bit. It then releases the line for the master's acknowledge, and `ctrl_q` is unchanged.
- R9: A STOP or a repeated START in the middle of a data byte discards the partial byte. After a repeated START a complete new transfer is accepted normally.
- R10: `sda_oe` changes only while the synchronized clock line is low, so it is constant throughout every clock high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| pwr_ok | input | 1 | Power-good indication; 0 suppresses every acknowledge |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |
| ctrl_q | output | 8 | Stored control byte |

## Verification
The assertions assume the following about the inputs:
- The bus clock period spans at least 16 system clocks.
- The master changes the data line only while the clock is low, except when it makes START or STOP.
- The master never issues STOP or START while the target holds the line low.

Under these conditions, every output change triggered by a falling clock settles well before the next rising clock. The stimulus keeps each bus half period at ten system clocks and moves the data line in the middle of the low phase. It models the line as a wired-AND of the master's level and the target's release.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_DONE
    } bus_state_t;

endpackage

// File: rtl/busctl_sync.sv
module busctl_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '1;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '1;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/busctl_cond.sv
module busctl_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/busctl_target.sv
module busctl_target
    import busctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pwr_ok,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ctrl_q
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0]        line_s;
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    bus_state_t        state, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              addr_hit;
    logic              ack_ok;

    busctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    busctl_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign addr_hit = (shreg[BYTE_W-1:1] == DEV_ADDR);
    assign ack_ok   = pwr_ok && ((state == ST_WDATA) || addr_hit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall && bit_cnt == CNT_FULL)
                        state_d = ack_ok ? ST_ADDR_ACK : ST_IDLE;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_d = shreg[0] ? ST_RDATA : ST_WDATA;
                end
                ST_WDATA: begin
                    if (scl_fall && bit_cnt == CNT_FULL)
                        state_d = ack_ok ? ST_WDATA_ACK : ST_DONE;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_d = ST_DONE;
                end
                ST_RDATA: begin
                    if (scl_fall && bit_cnt == CNT_LAST) state_d = ST_RDATA_ACK;
                end
                ST_RDATA_ACK: begin
                    if (scl_fall) state_d = ST_DONE;
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            ctrl_q  <= '0;
        end else if (stop_ev || start_ev) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bit_cnt < CNT_FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && bit_cnt == CNT_FULL) begin
                        sda_oe  <= ack_ok;
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (shreg[0]) begin
                            shreg  <= ctrl_q;
                            sda_oe <= ~ctrl_q[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        ctrl_q <= shreg;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == CNT_LAST) begin
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe  <= ~shreg[BYTE_W-2];
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    AST_ACK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) && (state == ST_ADDR_ACK || state == ST_WDATA_ACK) |-> $past(pwr_ok)); // R5

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) && !$past(start_ev || stop_ev) |-> !$past(scl_s)); // R10

    AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(state == ST_WDATA_ACK)); // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DONE) |-> !sda_oe); // R4

endmodule

// File: tb/busctl_target_tb.sv
module busctl_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int Q          = 5;
    localparam int WD_CYCLES  = 150000;
    localparam logic [6:0] MY_ADDR = 7'b0001000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pwr_ok = 1'b1;
    logic       sda_oe;
    logic [7:0] ctrl_q;
    logic       sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] exp_reg = 8'h00;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    busctl_target u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .pwr_ok (pwr_ok),
        .sda_oe (sda_oe),
        .ctrl_q (ctrl_q)
    );

    function automatic bit exp_addr_ack(input logic [6:0] a, input logic pg);
        return (a == MY_ADDR) && pg;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        wait_clk(Q); sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1;
        wait_clk(Q); sda_m = 1'b0; wait_clk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        wait_clk(Q); sda_m = 1'b0; wait_clk(Q); scl_m = 1'b1;
        wait_clk(Q); sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            wait_clk(Q); sda_m = b[7-i]; wait_clk(Q); scl_m = 1'b1;
            wait_clk(HALF); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a0, a1;
        send_bits(b, 8);
        wait_clk(Q); sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1;
        wait_clk(1); a0 = ~sda_line;
        wait_clk(HALF-2); a1 = ~sda_line;
        wait_clk(1); scl_m = 1'b0;
        chk(a0 == a1, "R10 ack level steady over clock high", int'(a1), int'(a0));
        ack = a0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q); sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1;
            wait_clk(Q); b[i] = sda_line;
            wait_clk(Q); scl_m = 1'b0;
        end
        wait_clk(Q); sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1;
        wait_clk(2);
        chk(sda_oe == 1'b0, "R8 line released for master ack", int'(sda_oe), 0);
        wait_clk(HALF-2); scl_m = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string tag);
        logic ack_a, ack_d;
        bit   ea;
        ea = exp_addr_ack(a, pwr_ok);
        bus_start();
        send_byte({a, 1'b0}, ack_a);
        chk(ack_a == ea, {tag, " address ack"}, int'(ack_a), int'(ea));
        send_byte(d, ack_d);
        chk(ack_d == (ea && pwr_ok), {tag, " data ack"}, int'(ack_d), int'(ea && pwr_ok));
        bus_stop();
        if (ea && pwr_ok) exp_reg = d;
        chk(ctrl_q == exp_reg, {tag, " register after write"}, int'(ctrl_q), int'(exp_reg));
    endtask

    task automatic do_read(input logic [6:0] a, input string tag);
        logic       ack_a;
        logic [7:0] got;
        bit         ea;
        ea = exp_addr_ack(a, pwr_ok);
        bus_start();
        send_byte({a, 1'b1}, ack_a);
        chk(ack_a == ea, {tag, " read address ack"}, int'(ack_a), int'(ea));
        if (ack_a) begin
            read_byte(got);
            chk(got == exp_reg, "R8 read data", int'(got), int'(exp_reg));
        end
        bus_stop();
        chk(ctrl_q == exp_reg, "R8 register unchanged by read", int'(ctrl_q), int'(exp_reg));
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        void'($urandom(32'd20240611));
        wait_clk(5);
        chk(ctrl_q == 8'h00, "R1 reset register", int'(ctrl_q), 0);
        chk(sda_oe == 1'b0, "R1 reset line released", int'(sda_oe), 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R2 R3 R6: basic write
        do_write(MY_ADDR, 8'hA5, "R6");
        do_write(MY_ADDR, 8'h3C, "R3");
        // R8 read back
        do_read(MY_ADDR, "R8");
        // R4 wrong address
        do_write(7'b0001001, 8'hFF, "R4");
        do_read(7'b1001000, "R4");
        // R5 power low
        pwr_ok = 1'b0;
        do_write(MY_ADDR, 8'h11, "R5");
        do_read(MY_ADDR, "R5");
        pwr_ok = 1'b1;

        // R7 second byte ignored
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h5A, ack);
        send_byte(8'hC3, ack);
        chk(ack == 1'b0, "R7 second byte not acked", int'(ack), 0);
        bus_stop();
        exp_reg = 8'h5A;
        chk(ctrl_q == exp_reg, "R7 register holds first byte", int'(ctrl_q), int'(exp_reg));

        // R9 STOP mid byte
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_bits(8'h0F, 4);
        bus_stop();
        chk(ctrl_q == exp_reg, "R9 stop discards partial byte", int'(ctrl_q), int'(exp_reg));

        // R9 repeated START mid byte, then full transfer
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_bits(8'hF0, 3);
        chk(ctrl_q == exp_reg, "R9 partial byte before restart", int'(ctrl_q), int'(exp_reg));
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk(ack == 1'b1, "R9 restart address acked", int'(ack), 1);
        send_byte(8'h96, ack);
        bus_stop();
        exp_reg = 8'h96;
        chk(ctrl_q == exp_reg, "R9 register after restart write", int'(ctrl_q), int'(exp_reg));

        // Random mix of transfers
        for (int t = 0; t < 24; t++) begin
            logic [6:0] a;
            logic [7:0] d;
            a = ($urandom % 4 == 0) ? 7'($urandom) : MY_ADDR;
            d = 8'($urandom);
            pwr_ok = ($urandom % 5 != 0);
            wait_clk(4);
            if ($urandom % 3 == 0) do_read(a, "R8");
            else                   do_write(a, d, "R6");
        end
        pwr_ok = 1'b1;
        do_read(MY_ADDR, "R8");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule